// File: doc/BRIEF.md
# DRAM Controller Register Bank with Key Lock

This block is the register bank that a DRAM controller exposes to software. Software reaches it over a word-indexed bus with separate read and write strobes. Every access is a full 32-bit word, and the address is a word index into a 4 KiB window. A protection word at index 0 holds a three-state lock, and the value written to that word chooses the state. The lock decides which configuration writes reach storage.

A fixed group of interrupt and test words stays writable in every lock state. Some writes are reshaped before they are stored: the configuration word keeps its read-only fields, the PHY status word never reads busy and always reads PLL-locked, and the self-test control word always reads finished and never reads failed. A two-bit strap gives the installed memory size, which the block places in the low bits of the configuration word.

Blocked writes and accesses outside the implemented words produce a one-cycle error pulse.

Top module: `dram_ctl_regbank`

## Requirements
- R1: Writing 0xFC600309 to index 0 (byte offset 0x00), while that word is writable, unlocks the bank. Index 0 then reads 0x00000001, and all implemented words accept writes.
- R2: Writing 0xDEADDEAD to index 0, while that word is writable, hard-locks the bank. Index 0 then reads 0x00000010. Every protected word, including index 0 itself, then ignores writes and raises the error pulse until the next reset.
- R3: Writing any other value to index 0, while that word is writable, soft-locks the bank, and index 0 reads 0x00000000. While soft-locked, writes to protected words other than index 0 are dropped and raise the error pulse. Index 0 itself still accepts writes.
- R4: The words at byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 store every write in every lock state, without an error pulse.
- R5: On the configuration word (offset 0x04), bits 31:28 always read 3, bits 19:14 always read 0, bit 6 always reads 0 and bits 3:2 always read 0b11. All other bits store the written value.
- R6: Configuration bits 1:0 hold the size code sampled from the strap (0 = 256 MiB, 1 = 512 MiB, 2 = 1 GiB, 3 = 2 GiB). On a configuration write they become the written bits 1:0 ORed with the strap code.
- R7: A write to offset 0x60 stores the data with bit 0 cleared and bit 4 set.
- R8: A write to offset 0x70 stores the data with bit 12 set and bit 13 cleared.
- R9: Synchronous reset leaves the bank soft-locked (index 0 reads 0). The configuration word resets to 0x3000000C ORed with the strap code. Every other word resets to 0.
- R10: An access at a word index of NumWords or above (byte offset 0xC0 or above by default) reads 0, changes no stored word, and raises the error pulse.
- R11: Read data appears on the output one cycle after the read strobe. A write is stored on the clock edge at which its strobe is sampled, so a read strobed in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 10 | Word index within the 4 KiB window |
| wrData | input | 32 | Write data |
| memSizeSel | input | 2 | Installed memory size strap |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| accErr | output | 1 | One-cycle pulse for a blocked write or an out-of-range access |

## Verification
The bound checker tests these properties on every cycle:
- the hard lock is sticky;
- a soft-locked protected write always raises the error pulse;
- the always-writable words never raise it;
- an out-of-range read returns zero with an error;
- the protection word only ever reads one of its three codes;
- every configuration read shows its fixed fields.

Some behaviour can only be shown by the bench scenarios, because it depends on the values written and on what is read back afterwards. This covers whether a blocked write really left the stored value untouched, how the status and self-test words are reshaped, the OR with the strap in the size field, and the reset value after the strap changes.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 10;
  localparam int SIZE_W = 2;

  typedef enum logic [1:0] {LK_SOFT = 2'd0, LK_OPEN = 2'd1, LK_HARD = 2'd2} lock_e;

  typedef struct packed {
    logic             wrCommit;
    logic             rdLatch;
    logic             rdInRange;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  localparam logic [IDX_W-1:0] IDX_KEY  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CONF = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_PHY  = IDX_W'(24);
  localparam logic [IDX_W-1:0] IDX_TEST = IDX_W'(28);

  localparam logic [WORD_W-1:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [WORD_W-1:0] KEY_HARD = 32'hDEAD_DEAD;

  localparam logic [WORD_W-1:0] CODE_SOFT = 32'h0000_0000;
  localparam logic [WORD_W-1:0] CODE_OPEN = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CODE_HARD = 32'h0000_0010;

  localparam logic [WORD_W-1:0] CONF_RO    = 32'hF00F_C04C;
  localparam logic [WORD_W-1:0] CONF_FIXED = 32'h3000_000C;

  localparam int PHY_BUSY_BIT  = 0;
  localparam int PHY_PLL_BIT   = 4;
  localparam int TEST_DONE_BIT = 12;
  localparam int TEST_FAIL_BIT = 13;

  // Words that bypass the lock (byte offsets 0x50,0x6C,0x74,0x78,0x7C,0x88,0x8C,0xB4)
  function automatic logic isAlwaysOpen(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(20), IDX_W'(27), IDX_W'(29), IDX_W'(30),
      IDX_W'(31), IDX_W'(34), IDX_W'(35), IDX_W'(45): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/regbank_ctrl.sv
`timescale 1ns/1ps
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int NumWords = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  addr,
  input  logic [WORD_W-1:0] wrData,
  output strobe_t           strobe,
  output lock_e             lockState,
  output logic              accErr
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NumWords - 1);

  logic  inRange;
  logic  isKey;
  logic  permit;
  logic  errNext;
  lock_e lockNext;

  assign inRange = (addr <= LastIdx);
  assign isKey   = (addr == IDX_KEY);

  // Hard lock leaves only the open group; soft lock also admits the key word.
  always_comb begin
    unique case (lockState)
      LK_OPEN: permit = 1'b1;
      LK_SOFT: permit = isAlwaysOpen(addr) || isKey;
      default: permit = isAlwaysOpen(addr);
    endcase
  end

  assign strobe.wrCommit  = wrEn && inRange && permit;
  assign strobe.rdLatch   = rdEn;
  assign strobe.rdInRange = inRange;
  assign strobe.idx       = addr;

  assign errNext = (wrEn && !(inRange && permit)) || (rdEn && !inRange);

  always_comb begin
    lockNext = lockState;
    if (strobe.wrCommit && isKey) begin
      if (wrData == KEY_OPEN)      lockNext = LK_OPEN;
      else if (wrData == KEY_HARD) lockNext = LK_HARD;
      else                         lockNext = LK_SOFT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState <= LK_SOFT;
      accErr    <= 1'b0;
    end else begin
      lockState <= lockNext;
      accErr    <= errNext;
    end
  end
endmodule

// File: rtl/regbank_store.sv
`timescale 1ns/1ps
module regbank_store
  import regbank_pkg::*;
#(
  parameter int NumWords = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [SIZE_W-1:0] sizeCode,
  input  lock_e             lockState,
  output logic [WORD_W-1:0] rdData
);
  localparam int SelW    = $clog2(NumWords);
  localparam int SlotCnt = 1 << SelW;

  logic [WORD_W-1:0] sizeWord;
  logic [WORD_W-1:0] confReset;
  logic [WORD_W-1:0] wrShaped;
  logic [WORD_W-1:0] lockCode;
  logic [WORD_W-1:0] slot [SlotCnt];

  assign sizeWord  = {{(WORD_W-SIZE_W){1'b0}}, sizeCode};
  assign confReset = CONF_FIXED | sizeWord;

  always_comb begin
    wrShaped = wrData;
    case (strobe.idx)
      IDX_CONF: wrShaped = (wrData & ~CONF_RO) | confReset;
      IDX_PHY: begin
        wrShaped[PHY_BUSY_BIT] = 1'b0;
        wrShaped[PHY_PLL_BIT]  = 1'b1;
      end
      IDX_TEST: begin
        wrShaped[TEST_DONE_BIT] = 1'b1;
        wrShaped[TEST_FAIL_BIT] = 1'b0;
      end
      default: ;
    endcase
  end

  generate
    for (genvar i = 0; i < SlotCnt; i++) begin : g_slot
      if (i == 0 || i >= NumWords) begin : g_empty
        assign slot[i] = '0;
      end else begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
          if (!rstN)
            q <= (i == int'(IDX_CONF)) ? confReset : '0;
          else if (strobe.wrCommit && strobe.idx == IDX_W'(i))
            q <= wrShaped;
        end
        assign slot[i] = q;
      end
    end
  endgenerate

  always_comb begin
    unique case (lockState)
      LK_OPEN: lockCode = CODE_OPEN;
      LK_HARD: lockCode = CODE_HARD;
      default: lockCode = CODE_SOFT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strobe.rdLatch) begin
      if (!strobe.rdInRange)            rdData <= '0;
      else if (strobe.idx == IDX_KEY)   rdData <= lockCode;
      else                              rdData <= slot[strobe.idx[SelW-1:0]];
    end
  end
endmodule

// File: rtl/dram_ctl_regbank.sv
`timescale 1ns/1ps
module dram_ctl_regbank
  import regbank_pkg::*;
#(
  parameter int NumWords = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [SIZE_W-1:0] memSizeSel,
  output logic [WORD_W-1:0] rdData,
  output logic              accErr
);
  strobe_t strobe;
  lock_e   lockState;

  regbank_ctrl #(.NumWords(NumWords)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strobe(strobe), .lockState(lockState), .accErr(accErr)
  );

  regbank_store #(.NumWords(NumWords)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .sizeCode(memSizeSel), .lockState(lockState), .rdData(rdData)
  );
endmodule

// File: rtl/regbank_chk.sv
`timescale 1ns/1ps
module regbank_chk
  import regbank_pkg::*;
#(
  parameter int NumWords = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [IDX_W-1:0]  addr,
  input logic [WORD_W-1:0] rdData,
  input logic              accErr,
  input lock_e             lockState
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NumWords - 1);

  a_r2_hard_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockState == LK_HARD |=> lockState == LK_HARD);

  a_r3_soft_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == LK_SOFT && wrEn && addr != IDX_KEY && addr <= LastIdx && !isAlwaysOpen(addr))
    |=> accErr);

  a_r4_open_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isAlwaysOpen(addr) && !rdEn) |=> !accErr);

  a_r10_oob_read: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rdEn) && $past(addr) > LastIdx) |-> (rdData == '0 && accErr));

  a_r1_key_codes: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rdEn) && $past(addr) == IDX_KEY)
    |-> (rdData == CODE_SOFT || rdData == CODE_OPEN || rdData == CODE_HARD));

  a_r5_conf_fixed: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rdEn) && $past(addr) == IDX_CONF)
    |-> (rdData[31:28] == 4'h3 && rdData[19:14] == 6'h0 && !rdData[6] && rdData[3:2] == 2'b11));
endmodule

bind dram_ctl_regbank regbank_chk #(.NumWords(NumWords)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .rdData(rdData), .accErr(accErr), .lockState(lockState)
);

// File: tb/sim_dram_ctl_regbank.sv
`timescale 1ns/1ps
module sim_dram_ctl_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  memSizeSel = 2'd2;
  logic [31:0] rdData;
  logic        accErr;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_ctl_regbank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .memSizeSel(memSizeSel), .rdData(rdData), .accErr(accErr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input int idx, input logic [31:0] d, output logic e);
    @(negedge clk); addr = 10'(idx); wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; e = accErr;
  endtask

  task automatic rd(input int idx, output logic [31:0] v, output logic e);
    @(negedge clk); addr = 10'(idx); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; v = rdData; e = accErr;
  endtask

  task automatic t_reset();
    logic [31:0] v; logic e;
    rd(0, v, e);  chk("R9", "key after reset", v, 32'h0);
    rd(1, v, e);  chk("R9", "conf after reset", v, 32'h3000_000E);
    rd(24, v, e); chk("R9", "phy after reset", v, 32'h0);
    chk("R9", "no error on read", {31'b0, e}, 32'h0);
  endtask

  task automatic t_soft_block();
    logic [31:0] v; logic e;
    wr(1, 32'h0, e);  chk("R3", "conf write error", {31'b0, e}, 32'h1);
    rd(1, v, e);      chk("R3", "conf unchanged", v, 32'h3000_000E);
    wr(16, 32'hA5A5_0001, e); chk("R3", "generic write error", {31'b0, e}, 32'h1);
    rd(16, v, e);     chk("R3", "generic unchanged", v, 32'h0);
  endtask

  task automatic t_unlock_shape();
    logic [31:0] v; logic e;
    wr(0, 32'hFC60_0309, e); chk("R1", "unlock no error", {31'b0, e}, 32'h0);
    rd(0, v, e);             chk("R1", "key reads open", v, 32'h1);
    wr(16, 32'hCAFE_0042, e); rd(16, v, e); chk("R11", "write then read", v, 32'hCAFE_0042);
    wr(24, 32'h1, e);        rd(24, v, e); chk("R7", "phy busy cleared pll set", v, 32'h10);
    wr(24, 32'hFFFF_FFFF, e); rd(24, v, e); chk("R7", "phy all ones", v, 32'hFFFF_FFFE);
    wr(28, 32'h2000, e);     rd(28, v, e); chk("R8", "test fail cleared", v, 32'h1000);
    wr(28, 32'hFFFF_FFFF, e); rd(28, v, e); chk("R8", "test all ones", v, 32'hFFFF_DFFF);
    wr(1, 32'hFFFF_FFFF, e); rd(1, v, e); chk("R5", "conf all ones", v, 32'h3FF0_3FBF);
    wr(1, 32'h1234_5678, e); rd(1, v, e); chk("R5", "conf pattern", v, 32'h3230_163E);
    wr(1, 32'h0, e);         rd(1, v, e); chk("R6", "conf zero keeps strap", v, 32'h3000_000E);
    wr(1, 32'h1, e);         rd(1, v, e); chk("R6", "size bits ORed", v, 32'h3000_000F);
  endtask

  task automatic t_relock();
    logic [31:0] v; logic e;
    wr(0, 32'h1234_5678, e); rd(0, v, e); chk("R3", "other value soft locks", v, 32'h0);
    wr(16, 32'h0, e);        rd(16, v, e); chk("R3", "generic kept", v, 32'hCAFE_0042);
    wr(0, 32'hFC60_0309, e); rd(0, v, e); chk("R3", "key writable when soft", v, 32'h1);
    wr(0, 32'h0, e);
  endtask

  task automatic t_open_group();
    int offs[8] = '{20, 27, 29, 30, 31, 34, 35, 45};
    logic [31:0] v; logic e;
    foreach (offs[k]) begin
      wr(offs[k], 32'h5500_0000 + 32'(k), e);
      chk("R4", "open write no error", {31'b0, e}, 32'h0);
      rd(offs[k], v, e);
      chk("R4", "open readback", v, 32'h5500_0000 + 32'(k));
    end
  endtask

  task automatic t_hard();
    logic [31:0] v; logic e;
    wr(0, 32'hFC60_0309, e);
    wr(0, 32'hDEAD_DEAD, e); rd(0, v, e); chk("R2", "hard code", v, 32'h10);
    wr(0, 32'hFC60_0309, e); chk("R2", "key write error", {31'b0, e}, 32'h1);
    rd(0, v, e);             chk("R2", "still hard", v, 32'h10);
    wr(1, 32'h0000_0F00, e); rd(1, v, e); chk("R2", "conf kept", v, 32'h3000_000F);
    wr(20, 32'h7777_0000, e); rd(20, v, e); chk("R4", "open under hard", v, 32'h7777_0000);
  endtask

  task automatic t_oob();
    logic [31:0] v; logic e;
    wr(48, 32'hFFFF_FFFF, e); chk("R10", "oob write error", {31'b0, e}, 32'h1);
    rd(48, v, e);  chk("R10", "oob read zero", v, 32'h0);
    chk("R10", "oob read error", {31'b0, e}, 32'h1);
    rd(1023, v, e); chk("R10", "top index zero", v, 32'h0);
    rd(47, v, e);  chk("R10", "last word in range", {31'b0, e}, 32'h0);
  endtask

  task automatic t_reset_strap();
    logic [31:0] v; logic e;
    memSizeSel = 2'd0;
    doReset();
    rd(0, v, e);  chk("R9", "hard cleared by reset", v, 32'h0);
    rd(1, v, e);  chk("R9", "conf with strap 0", v, 32'h3000_000C);
    rd(20, v, e); chk("R9", "open word cleared", v, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    t_reset();
    t_soft_block();
    t_unlock_shape();
    t_relock();
    t_open_group();
    t_hard();
    t_oob();
    t_reset_strap();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule